// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is a 4-bit up-counter. Its state bits all change together on the rising clock edge. It has a parallel preset, an active-low clear, and two count enables. One enable, the trickle enable, also gates the carry output. Because of this, several copies can be chained into a wider synchronous counter with no glue logic. Each stage's carry drives the trickle enable of the next stage, and all stages share the clock and the parallel enable.

Two elaboration parameters fix the variant. `DECADE` picks binary counting (modulo 16) or decade counting (modulo 10). `ASYNC_CLR` picks a clear that waits for the clock edge or a clear that acts at once.

Top module: `cascade_counter4`

## Requirements
- R1: In the synchronous-clear variant, `clr_n` low sets `q` to 0 at the next rising edge, whatever `load_n`, `en_p` and `en_t` are.
- R2: With `clr_n` high and `load_n` low, `q` takes the value of `din` at the next rising edge, whatever the enables are.
- R3: With `clr_n` and `load_n` high, `q` advances by one at a rising edge only when `en_p` and `en_t` are both high. Otherwise `q` holds.
- R4: In binary mode the count wraps from 15 to 0.
- R5: `carry_out` is high exactly when `en_t` is high and `q` equals the terminal value (15 in binary mode, 9 in decade mode). This is combinational, so it follows `en_t` without waiting for a clock edge.
- R6: In decade mode the count wraps from 9 to 0.
- R7: In decade mode, a preset of 10 to 15 steps up by one per enabled edge, goes from 15 to 0, and never raises `carry_out`.
- R8: In the asynchronous-clear variant, `clr_n` low forces `q` to 0 at once, without a clock edge.
- R9: Changes on `load_n`, `en_p` or `en_t` between rising edges leave `q` unchanged until the next edge.
- R10: Two binary stages wired with the low stage's `carry_out` on the high stage's `en_t`, sharing `clk` and `en_p`, count 0 to 255 and wrap as one 8-bit synchronous counter.
- R11: Clear takes priority over load, and load takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (synchronous or asynchronous, set by parameter) |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `carry_out` |
| din | input | 4 | Preset data |
| q | output | 4 | Count value |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
The bench drives each enable low by itself and confirms the count holds. A design that used only one enable would count here. It holds `en_t` steady at the terminal count, then drops it and expects the carry to fall in the same cycle. A registered carry would lag by one cycle and break a chain. It runs a two-stage chain through more than one full 8-bit wrap; a carry that fires one count early or late shows up as a high byte that steps at the wrong time. In decade mode it presets values from 10 to 15 and expects a plain increment with no carry. It also expects the register to collapse to 0 between edges in the asynchronous variant. It asserts clear and load together to confirm that clear wins.

// File: rtl/ccnt_pkg.sv
// Package: shared operation code for the counter's next-state logic.
// Assumes: clear is handled in the state register, not in this code.
package ccnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } ccnt_op_e;
endpackage

// File: rtl/ccnt_ctrl.sv
// Module: ccnt_ctrl
// Decodes the load and enable controls into one operation.
// Assumes: clear is applied after this decode, so load beats count here
// and clear beats both in the register.
module ccnt_ctrl
    import ccnt_pkg::*;
(
    input  logic     load_n,
    input  logic     en_p,
    input  logic     en_t,
    output ccnt_op_e op
);
    // Pick the operation by priority: load first, then count, else hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ccnt_next.sv
// Module: ccnt_next
// Computes the next count from the operation, current count and preset.
// Assumes: a decade count from 10 to 15 is advanced as plain binary, so
// 15 rolls to 0 through the natural width overflow.
module ccnt_next
    import ccnt_pkg::*;
#(
    parameter int          WIDTH  = 4,
    parameter logic [WIDTH-1:0] TERM = '1,
    parameter bit          DECADE = 1'b0
) (
    input  ccnt_op_e         op,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] d
);
    logic [WIDTH-1:0] inc;

    // Step value: wrap at the terminal count in decade mode.
    generate
        if (DECADE) begin : g_dec
            always_comb inc = (q == TERM) ? '0 : q + 1'b1;
        end else begin : g_bin
            always_comb inc = q + 1'b1;
        end
    endgenerate

    // Select the next state for the operation.
    always_comb begin
        unique case (op)
            OP_LOAD:  d = din;
            OP_COUNT: d = inc;
            default:  d = q;
        endcase
    end
endmodule

// File: rtl/ccnt_reg.sv
// Module: ccnt_reg
// State register with a clear that is synchronous or asynchronous.
// Assumes: clr_n is active low and overrides the next-state value.
module ccnt_reg #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (ASYNC_CLR) begin : g_async
            // Store the next state; clear at once when clr_n falls.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_sync
            // Store the next state; clear only on the clock edge.
            always_ff @(posedge clk) begin
                if (!clr_n) q <= '0;
                else        q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/cascade_counter4.sv
// Module: cascade_counter4
// 4-bit presettable synchronous up-counter with a carry for chaining.
// Assumes: DECADE is used with WIDTH 4; en_t feeds the carry directly, so
// the carry is combinational and can ripple through a chain.
module cascade_counter4
    import ccnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    ccnt_op_e         op;
    logic [WIDTH-1:0] d;

    ccnt_ctrl u_ctrl (
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    ccnt_next #(.WIDTH(WIDTH), .TERM(TERM), .DECADE(DECADE)) u_next (
        .op  (op),
        .q   (q),
        .din (din),
        .d   (d)
    );

    ccnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (d),
        .q     (q)
    );

    // Carry: trickle enable qualified by the terminal count.
    always_comb carry_out = en_t && (q == TERM);
endmodule

// File: rtl/ccnt_checker.sv
// Module: ccnt_checker
// Property checks for cascade_counter4, attached with bind.
module ccnt_checker #(
    parameter int WIDTH     = 4,
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] MAXV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    logic started = 1'b0;
    // Mark that at least one edge has been seen.
    always_ff @(posedge clk) started <= 1'b1;

    function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] v);
        if (DECADE && v == MAXV) return '0;
        return v + 1'b1;
    endfunction

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> (q == step($past(q))));          // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));                  // R3
    AST_LOAD_DIN: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (q == $past(din)));                             // R2
    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_t) |-> (!carry_out));                                    // R5
    AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (q == MAXV));                                   // R5

    generate
        if (ASYNC_CLR) begin : g_async_chk
            AST_ASYNC_ZERO: assert property (@(posedge clk) disable iff (!started)
                (!clr_n) |-> (q == '0));                              // R8
        end else begin : g_sync_chk
            AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!started)
                (!clr_n) |=> (q == '0));                              // R1
        end
    endgenerate
endmodule

bind cascade_counter4 ccnt_checker #(
    .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q), .carry_out(carry_out)
);

// File: tb/cascade_counter4_bench.sv
// Bench: directed scenarios over binary, chained, decade and async variants.
module cascade_counter4_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Binary sync pair (low stage is the main instance, high stage chained)
    logic       b_clr_n = 1'b0, b_load_n = 1'b1, b_en_p = 1'b0, b_en_t = 1'b0;
    logic [3:0] b_din = '0;
    logic [3:0] lo_q, hi_q;
    logic       lo_c, hi_c;

    cascade_counter4 u_cascade_counter4 (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .en_p(b_en_p),
        .en_t(b_en_t), .din(b_din), .q(lo_q), .carry_out(lo_c));
    cascade_counter4 u_hi (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .en_p(b_en_p),
        .en_t(lo_c), .din(b_din), .q(hi_q), .carry_out(hi_c));

    // Decade sync instance
    logic       d_clr_n = 1'b0, d_load_n = 1'b1, d_en_p = 1'b0, d_en_t = 1'b0;
    logic [3:0] d_din = '0;
    logic [3:0] d_q;
    logic       d_c;
    cascade_counter4 #(.DECADE(1'b1)) u_dec (
        .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .en_p(d_en_p),
        .en_t(d_en_t), .din(d_din), .q(d_q), .carry_out(d_c));

    // Binary async-clear instance
    logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_en_p = 1'b0, a_en_t = 1'b0;
    logic [3:0] a_din = '0;
    logic [3:0] a_q;
    logic       a_c;
    cascade_counter4 #(.ASYNC_CLR(1'b1)) u_async (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .en_p(a_en_p),
        .en_t(a_en_t), .din(a_din), .q(a_q), .carry_out(a_c));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        b_clr_n = 1'b0; b_load_n = 1'b0; b_din = 4'd5; b_en_p = 1'b1; b_en_t = 1'b1;
        tick();
        check("R1 clear to zero", lo_q, 0);
        check("R11 clear beats load", hi_q, 0);
        check("R5 carry low at zero", lo_c, 0);
        b_clr_n = 1'b1; b_load_n = 1'b1; b_en_p = 1'b0; b_en_t = 1'b0;
    endtask

    task automatic t_load();
        b_load_n = 1'b0; b_din = 4'd10;
        tick();
        check("R2 load with enables low", lo_q, 10);
        b_din = 4'd3; b_en_p = 1'b1; b_en_t = 1'b1;
        tick();
        check("R11 load beats count", lo_q, 3);
        b_load_n = 1'b1; b_en_p = 1'b0; b_en_t = 1'b0;
    endtask

    task automatic t_enables();
        b_en_p = 1'b1; b_en_t = 1'b0;
        tick();
        check("R3 hold with en_t low", lo_q, 3);
        b_en_p = 1'b0; b_en_t = 1'b1;
        tick();
        check("R3 hold with en_p low", lo_q, 3);
        b_en_p = 1'b1;
        tick();
        check("R3 count with both high", lo_q, 4);
        b_en_p = 1'b0; b_en_t = 1'b0;
    endtask

    task automatic t_between_edges();
        b_load_n = 1'b0; b_din = 4'd9; b_en_p = 1'b1; b_en_t = 1'b1;
        #2;
        check("R9 no change mid-cycle", lo_q, 4);
        b_load_n = 1'b1; b_en_p = 1'b0; b_en_t = 1'b0;
        tick();
        check("R9 edge sees final controls", lo_q, 4);
    endtask

    task automatic t_wrap_carry();
        b_load_n = 1'b0; b_din = 4'd14;
        tick();
        b_load_n = 1'b1; b_en_p = 1'b1; b_en_t = 1'b1;
        #1;
        check("R5 carry low below terminal", lo_c, 0);
        tick();
        check("R4 reach 15", lo_q, 15);
        check("R5 carry high at 15", lo_c, 1);
        b_en_t = 1'b0;
        #1;
        check("R5 carry follows en_t", lo_c, 0);
        b_en_t = 1'b1;
        tick();
        check("R4 wrap 15 to 0", lo_q, 0);
        check("R5 carry low after wrap", lo_c, 0);
        b_en_p = 1'b0; b_en_t = 1'b0;
    endtask

    task automatic t_chain();
        b_clr_n = 1'b0;
        tick();
        b_clr_n = 1'b1; b_en_p = 1'b1; b_en_t = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            tick();
            check("R10 chained 8-bit count", {hi_q, lo_q}, i % 256);
        end
        b_en_p = 1'b0; b_en_t = 1'b0;
    endtask

    task automatic t_decade();
        d_clr_n = 1'b0;
        tick();
        check("R1 decade clear", d_q, 0);
        d_clr_n = 1'b1; d_en_p = 1'b1; d_en_t = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            tick();
            check("R6 decade count", d_q, i);
            check("R5 decade carry", d_c, (i == 9) ? 1 : 0);
        end
        tick();
        check("R6 decade wrap 9 to 0", d_q, 0);
        d_load_n = 1'b0; d_din = 4'd12;
        tick();
        d_load_n = 1'b1;
        check("R7 preset above nine", d_q, 12);
        for (int i = 13; i <= 16; i++) begin
            tick();
            check("R7 step from illegal value", d_q, i % 16);
            check("R7 no carry out of range", d_c, 0);
        end
        d_en_p = 1'b0; d_en_t = 1'b0;
    endtask

    task automatic t_async();
        a_clr_n = 1'b1; a_load_n = 1'b0; a_din = 4'd7;
        tick();
        a_load_n = 1'b1;
        check("R2 async variant load", a_q, 7);
        #1;
        a_clr_n = 1'b0; a_load_n = 1'b0; a_din = 4'd11;
        #1;
        check("R8 immediate clear", a_q, 0);
        tick();
        check("R8 clear held over load", a_q, 0);
        a_clr_n = 1'b1; a_load_n = 1'b1;
        tick();
        check("R8 holds after release", a_q, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_load();
        t_enables();
        t_between_edges();
        t_wrap_carry();
        t_chain();
        t_decade();
        t_async();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule